// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block manages a set of external interrupt request lines for a small processor core. Each line has its own enable, pending and active state and a programmable priority value. Every cycle the block picks the most urgent request that is both pending and enabled. It then decides whether that request may start now. If no handler is running it always may. If a handler is running, the request must be strictly more urgent in the preemption part of its priority. When a request is taken, the block presents the line number and the address of its handler entry. That address is the programmable table base plus four bytes per line number.

A group setting splits each priority value into two parts. Its upper bits form the preemption level and its lower bits form the subpriority. The full value orders requests that are waiting to be taken. Only the preemption level decides whether a running handler is interrupted. A handler-done strobe retires the most recently taken handler, and the running level is then recomputed from the handlers that are still active. In the same cycle as that strobe, the block may start the next eligible request directly (tail-chaining). Software reaches every register through a single-cycle write port and a combinational read port.

Top module: `prio_nest_intc`

## Requirements
- R1: After reset the enable, pending and active masks read 0, the table base reads 0, every priority reads 0, the group setting reads PRIO_W and vecValid is low.
- R2: Writing address 0 sets the enable bits that are 1 in the write data, and writing address 1 clears them. Reading address 0 or 1 returns the enable mask, one bit per line with bit i for line i.
- R3: A rising edge on irqReq[i] sets pending bit i whether or not the line is enabled. Writing address 2 sets the pending bits given as 1, and writing address 3 clears them. Reading address 2 or 3 returns the pending mask. A disabled pending line is serviced once it is enabled.
- R4: Only lines that are pending, enabled and not active take part in selection. The lowest full priority value wins (priority of line i at address 16+i, low PRIO_W bits), and ties go to the lower line number.
- R5: A take raises vecValid on the next clock edge. vecNum then shows the line, and vecAddr equals the table base (address 6) plus 4 times the line number. Both are held until vecAck. While vecValid is high no new take happens. A take clears the line's pending bit and sets its active bit, which can be read at address 4.
- R6: The preemption level is the priority shifted right by PRIO_W minus G, where G is the group setting at address 5. While any handler is active, a request is taken only if its level is strictly below the lowest level among the active lines. With G equal to 0, no request preempts.
- R7: A handlerDone pulse clears the active bit of the most recently taken line that is still active, and the running level then comes from the remaining active lines.
- R8: In the cycle of a handlerDone pulse, the take decision already uses the active set without the retired line, so the next request can be taken on that same clock edge.
- R9: A write of a value larger than PRIO_W to address 5 stores PRIO_W.
- R10: A handlerDone pulse while no line is active changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | NUM_LINES | Interrupt request lines, rising-edge sensitive |
| regWe | input | 1 | Register write strobe |
| regAddr | input | RA_W | Register address for write and read |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Combinational read data for regAddr |
| vecValid | output | 1 | A taken interrupt is presented |
| vecNum | output | IDX_W | Line number of the taken interrupt |
| vecAddr | output | ADDR_W | Handler fetch address |
| vecAck | input | 1 | Acknowledge of the presented vector |
| handlerDone | input | 1 | End-of-handler strobe |

## Verification
Simultaneous requests with distinct priorities, with equal full priorities and with equal levels but different subpriorities show whether the winner comes from the value order and from the index tie-break. Nested sequences under group settings 4, 2 and 0 show the difference between a strict preemption win and a subpriority-only win, and show when preemption is switched off entirely. Done pulses that arrive while requests are waiting show whether tail-chaining happens on the same edge and whether the correct handler of a nest is retired. A long random mix of request edges, register writes, acknowledges and done pulses is compared on every cycle against a behavioural model.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_EN_SET   = 0;
  localparam int ADDR_EN_CLR   = 1;
  localparam int ADDR_PEND_SET = 2;
  localparam int ADDR_PEND_CLR = 3;
  localparam int ADDR_ACTIVE   = 4;
  localparam int ADDR_GROUP    = 5;
  localparam int ADDR_BASE     = 6;
  localparam int PRIO_BASE     = 16;

  typedef struct packed {
    logic take;
    logic pop;
  } ctrl_strobe_t;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N = 16,
  parameter int VAL_W = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       cand,
  input  logic [N*VAL_W-1:0] vals,
  output logic               found,
  output logic [IDX_W-1:0]   idx,
  output logic [VAL_W-1:0]   val
);
  // lowest value wins; scanning upward with a strict compare keeps the lower index on ties
  always_comb begin
    found = 1'b0;
    idx   = '0;
    val   = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || vals[i*VAL_W +: VAL_W] < val)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        val   = vals[i*VAL_W +: VAL_W];
      end
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int N = 16,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RA_W = 5,
  localparam int IDX_W = $clog2(N),
  localparam int GW = $clog2(PRIO_W + 1),
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N-1:0]       irqReq,
  input  logic               regWe,
  input  logic [RA_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  ctrl_strobe_t       strobe,
  input  logic [IDX_W-1:0]   takeNum,
  output logic               pendFound,
  output logic [IDX_W-1:0]   pendIdx,
  output logic [PRIO_W-1:0]  pendPre,
  output logic               actFound,
  output logic [PRIO_W-1:0]  actPre,
  output logic               stackEmpty,
  output logic [ADDR_W-1:0]  tableBase
);
  logic [N-1:0] enMask, pendMask, actMask, irqPrev;
  logic [GW-1:0] grp;
  logic [PRIO_W-1:0] prioArr [N];
  logic [N*PRIO_W-1:0] prioFlat, preFlat;
  logic [IDX_W-1:0] stk [N];
  logic [CNT_W-1:0] depth;
  logic [IDX_W-1:0] topSlot, topIdx, pushSlot, actIdx;
  logic [N-1:0] lineWord, takeBit, popBit, actAfterPop, riseMask;
  logic [PRIO_W-1:0] pendPrio;
  logic wrEnSet, wrEnClr, wrPendSet, wrPendClr, wrGroup, wrBase;

  assign wrEnSet   = regWe && regAddr == RA_W'(ADDR_EN_SET);
  assign wrEnClr   = regWe && regAddr == RA_W'(ADDR_EN_CLR);
  assign wrPendSet = regWe && regAddr == RA_W'(ADDR_PEND_SET);
  assign wrPendClr = regWe && regAddr == RA_W'(ADDR_PEND_CLR);
  assign wrGroup   = regWe && regAddr == RA_W'(ADDR_GROUP);
  assign wrBase    = regWe && regAddr == RA_W'(ADDR_BASE);

  assign lineWord = regWdata[N-1:0];
  assign riseMask = irqReq & ~irqPrev;
  assign takeBit  = strobe.take ? (N'(1) << takeNum) : '0;
  assign topSlot  = IDX_W'(depth - CNT_W'(1));
  assign topIdx   = stk[topSlot];
  assign pushSlot = strobe.pop ? topSlot : IDX_W'(depth);
  assign popBit   = strobe.pop ? (N'(1) << topIdx) : '0;
  assign actAfterPop = actMask & ~popBit;
  assign stackEmpty  = depth == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask    <= '0;
      pendMask  <= '0;
      actMask   <= '0;
      irqPrev   <= '0;
      grp       <= GW'(PRIO_W);
      tableBase <= '0;
    end else begin
      irqPrev <= irqReq;
      if (wrEnSet) enMask <= enMask | lineWord;
      else if (wrEnClr) enMask <= enMask & ~lineWord;
      pendMask <= (pendMask & ~(wrPendClr ? lineWord : '0) & ~takeBit)
                | riseMask | (wrPendSet ? lineWord : '0);
      actMask <= actAfterPop | takeBit;
      if (wrGroup) begin
        if (regWdata > DATA_W'(PRIO_W)) grp <= GW'(PRIO_W);
        else grp <= GW'(regWdata);
      end
      if (wrBase) tableBase <= regWdata[ADDR_W-1:0];
    end
  end

  // activation order, so a done strobe retires the newest handler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) depth <= '0;
    else if (strobe.take && !strobe.pop) depth <= depth + CNT_W'(1);
    else if (strobe.pop && !strobe.take) depth <= depth - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (strobe.take) stk[pushSlot] <= takeNum;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prioArr[i] <= '0;
      else if (regWe && int'(regAddr) == PRIO_BASE + i) prioArr[i] <= regWdata[PRIO_W-1:0];
    end
    assign prioFlat[i*PRIO_W +: PRIO_W] = prioArr[i];
    assign preFlat[i*PRIO_W +: PRIO_W]  = prioArr[i] >> (PRIO_W - int'(grp));
  end

  intc_arbiter #(.N(N), .VAL_W(PRIO_W)) u_pendArb (
    .cand (pendMask & enMask & ~actMask),
    .vals (prioFlat),
    .found(pendFound),
    .idx  (pendIdx),
    .val  (pendPrio)
  );

  intc_arbiter #(.N(N), .VAL_W(PRIO_W)) u_actArb (
    .cand (actAfterPop),
    .vals (preFlat),
    .found(actFound),
    .idx  (actIdx),
    .val  (actPre)
  );

  assign pendPre = pendPrio >> (PRIO_W - int'(grp));

  always_comb begin
    regRdata = '0;
    case (regAddr)
      RA_W'(ADDR_EN_SET), RA_W'(ADDR_EN_CLR):     regRdata = DATA_W'(enMask);
      RA_W'(ADDR_PEND_SET), RA_W'(ADDR_PEND_CLR): regRdata = DATA_W'(pendMask);
      RA_W'(ADDR_ACTIVE): regRdata = DATA_W'(actMask);
      RA_W'(ADDR_GROUP):  regRdata = DATA_W'(grp);
      RA_W'(ADDR_BASE):   regRdata = DATA_W'(tableBase);
      default: begin
        if (int'(regAddr) >= PRIO_BASE && int'(regAddr) < PRIO_BASE + N)
          regRdata = DATA_W'(prioArr[IDX_W'(int'(regAddr) - PRIO_BASE)]);
      end
    endcase
  end

  // R4: the control only takes a line that is pending, enabled and idle
  a_r4_take_eligible: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> (pendMask[takeNum] && enMask[takeNum] && !actMask[takeNum]));

  // R5: a take leaves the line active
  a_r5_take_activates: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> actMask[$past(takeNum)]);

  // R6: nesting can never exceed one entry per line
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && !strobe.pop) |-> depth < CNT_W'(N));

  // R7: the retired entry is an active line
  a_r7_pop_active: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> actMask[topIdx]);

  // R7: running level comes from a line still active after the retirement
  a_r7_run_from_active: assert property (@(posedge clk) disable iff (!rstN)
    actFound |-> actAfterPop[actIdx]);
endmodule

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
#(
  parameter int N = 16,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pendFound,
  input  logic [IDX_W-1:0]  pendIdx,
  input  logic [PRIO_W-1:0] pendPre,
  input  logic              actFound,
  input  logic [PRIO_W-1:0] actPre,
  input  logic              stackEmpty,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic              vecAck,
  input  logic              handlerDone,
  output ctrl_strobe_t      strobe,
  output logic [IDX_W-1:0]  takeNum,
  output logic              vecValid,
  output logic [IDX_W-1:0]  vecNum,
  output logic [ADDR_W-1:0] vecAddr
);
  always_comb begin
    strobe.pop  = handlerDone && !stackEmpty;
    strobe.take = !vecValid && pendFound && (!actFound || pendPre < actPre);
    takeNum     = pendIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecNum   <= '0;
      vecAddr  <= '0;
    end else if (strobe.take) begin
      vecValid <= 1'b1;
      vecNum   <= pendIdx;
      vecAddr  <= tableBase + (ADDR_W'(pendIdx) << 2);
    end else if (vecAck) begin
      vecValid <= 1'b0;
    end
  end

  // R5: the presented vector is held until acknowledged
  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && !vecAck) |=> (vecValid && $stable(vecNum) && $stable(vecAddr)));

  // R5: vector is word aligned relative to the base at take time
  a_r5_addr_offset: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> (vecAddr - $past(tableBase)) == (ADDR_W'(vecNum) << 2));
endmodule

// File: rtl/prio_nest_intc.sv
module prio_nest_intc
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int RA_W = $clog2(PRIO_BASE + NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic                 regWe,
  input  logic [RA_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 vecValid,
  output logic [IDX_W-1:0]     vecNum,
  output logic [ADDR_W-1:0]    vecAddr,
  input  logic                 vecAck,
  input  logic                 handlerDone
);
  ctrl_strobe_t strobe;
  logic [IDX_W-1:0] takeNum, pendIdx;
  logic [PRIO_W-1:0] pendPre, actPre;
  logic pendFound, actFound, stackEmpty;
  logic [ADDR_W-1:0] tableBase;

  intc_datapath #(.N(NUM_LINES), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
                  .DATA_W(DATA_W), .RA_W(RA_W)) u_dp (
    .clk, .rstN, .irqReq, .regWe, .regAddr, .regWdata, .regRdata,
    .strobe, .takeNum, .pendFound, .pendIdx, .pendPre,
    .actFound, .actPre, .stackEmpty, .tableBase
  );

  intc_control #(.N(NUM_LINES), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk, .rstN, .pendFound, .pendIdx, .pendPre, .actFound, .actPre,
    .stackEmpty, .tableBase, .vecAck, .handlerDone,
    .strobe, .takeNum, .vecValid, .vecNum, .vecAddr
  );
endmodule

// File: tb/test_prio_nest_intc.sv
`timescale 1ns/1ps
module test_prio_nest_intc;
  localparam int N = 16;
  localparam int PW = 4;
  localparam int RAW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] irqReq = '0;
  logic regWe = 1'b0;
  logic [RAW-1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic vecValid;
  logic [3:0] vecNum;
  logic [31:0] vecAddr;
  logic vecAck = 1'b0;
  logic handlerDone = 1'b0;

  always #2.5 clk = ~clk;

  prio_nest_intc i_prio_nest_intc (
    .clk, .rstN, .irqReq, .regWe, .regAddr, .regWdata, .regRdata,
    .vecValid, .vecNum, .vecAddr, .vecAck, .handlerDone
  );

  int nChecks = 0;
  int nFail = 0;
  string curReq = "R1";
  bit finished = 0;
  bit mReady = 0;

  // behavioural reference state
  bit [N-1:0] mEn, mPend, mAct, mPrev;
  int mPrio [N];
  int mGrp;
  logic [31:0] mBase;
  int mStack [$];
  bit mVv;
  int mNum;
  logic [31:0] mAddr;

  function automatic int preOf(int p, int g);
    if (g == 0) return 0;
    return p / (1 << (PW - g));
  endfunction

  function automatic logic [31:0] mRead(int a);
    if (a == 0 || a == 1) return 32'(mEn);
    if (a == 2 || a == 3) return 32'(mPend);
    if (a == 4) return 32'(mAct);
    if (a == 5) return 32'(mGrp);
    if (a == 6) return mBase;
    if (a >= 16 && a < 16 + N) return 32'(mPrio[a-16]);
    return 32'd0;
  endfunction

  task automatic modelStep();
    bit [N-1:0] setM, clrM, actAfter;
    int best, minPre, a;
    bit anyAct, take, pop;
    a = int'(regAddr);
    setM = irqReq & ~mPrev;
    clrM = '0;
    if (regWe && a == 2) setM |= regWdata[N-1:0];
    if (regWe && a == 3) clrM = regWdata[N-1:0];
    pop = handlerDone && mStack.size() > 0;
    actAfter = mAct;
    if (pop) actAfter[mStack[$]] = 1'b0;
    best = -1;
    for (int i = 0; i < N; i++)
      if (mPend[i] && mEn[i] && !mAct[i] && (best < 0 || mPrio[i] < mPrio[best])) best = i;
    anyAct = 0;
    minPre = 1 << 20;
    for (int i = 0; i < N; i++)
      if (actAfter[i]) begin
        anyAct = 1;
        if (preOf(mPrio[i], mGrp) < minPre) minPre = preOf(mPrio[i], mGrp);
      end
    take = !mVv && best >= 0 && (!anyAct || preOf(mPrio[best], mGrp) < minPre);
    mPend = mPend & ~clrM;
    if (take) mPend[best] = 1'b0;
    mPend |= setM;
    mAct = actAfter;
    if (take) mAct[best] = 1'b1;
    if (pop) void'(mStack.pop_back());
    if (take) mStack.push_back(best);
    if (take) begin
      mVv = 1;
      mNum = best;
      mAddr = mBase + 32'(4 * best);
    end else if (vecAck) mVv = 0;
    if (regWe) begin
      if (a == 0) mEn |= regWdata[N-1:0];
      if (a == 1) mEn &= ~regWdata[N-1:0];
      if (a == 5) mGrp = (regWdata > 32'(PW)) ? PW : int'(regWdata);
      if (a == 6) mBase = regWdata;
      if (a >= 16 && a < 16 + N) mPrio[a-16] = int'(regWdata[PW-1:0]);
    end
    mPrev = irqReq;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = '0; mPend = '0; mAct = '0; mPrev = '0;
      for (int i = 0; i < N; i++) mPrio[i] = 0;
      mGrp = PW; mBase = '0; mStack.delete();
      mVv = 0; mNum = 0; mAddr = '0;
      mReady = 1;
    end else if (mReady) begin
      modelStep();
    end
  end

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual %h expected %h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  // compared every cycle, away from the active edge
  always @(negedge clk) begin
    if (mReady && !finished) begin
      #1;
      check(vecValid == mVv, "vecValid", 32'(vecValid), 32'(mVv));
      if (mVv) begin
        check(int'(vecNum) == mNum, "vecNum", 32'(vecNum), 32'(mNum));
        check(vecAddr == mAddr, "vecAddr", vecAddr, mAddr);
      end
      check(regRdata == mRead(int'(regAddr)), "regRdata", regRdata, mRead(int'(regAddr)));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    regWe = 1'b1; regAddr = RAW'(a); regWdata = d;
    tick(1);
    regWe = 1'b0;
  endtask

  task automatic rd(int a);
    regAddr = RAW'(a);
    tick(1);
  endtask

  task automatic pulse(int line);
    irqReq[line] = 1'b1;
    tick(1);
    irqReq[line] = 1'b0;
    tick(1);
  endtask

  task automatic ackVec();
    int guard = 0;
    while (!mVv && guard < 20) begin tick(1); guard++; end
    vecAck = 1'b1;
    tick(1);
    vecAck = 1'b0;
  endtask

  task automatic done();
    handlerDone = 1'b1;
    tick(1);
    handlerDone = 1'b0;
    tick(1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog expired, actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    // R1: reset values on every address
    curReq = "R1";
    for (int a = 0; a < 16 + N; a++) rd(a);

    // R2: enable set and clear
    curReq = "R2";
    wr(0, 32'h00FF); rd(0);
    wr(1, 32'h000F); rd(1); rd(0);

    // R3: edges on a disabled line, pending set and clear by write
    curReq = "R3";
    rd(2);
    pulse(9); rd(2);
    wr(3, 32'h0200); rd(3);
    pulse(9);
    wr(2, 32'h1000); rd(2);

    // R4: selection by value, ties to the lower number; R5 take and hold
    curReq = "R4";
    wr(6, 32'h0000_1000);
    wr(20, 6); wr(21, 3); wr(22, 3);
    wr(2, 32'h0070);
    curReq = "R5";
    rd(4); tick(3); rd(2);
    ackVec(); rd(4);
    // R8: done retires 5 and 6 is taken on the same edge
    curReq = "R8";
    done(); ackVec(); done(); ackVec(); done(); rd(4);

    // R6: group 2, subpriority does not preempt, a lower level does
    curReq = "R6";
    wr(5, 2);
    wr(20, 9); wr(21, 8); wr(22, 4);
    wr(2, 32'h0010); ackVec();
    wr(2, 32'h0020); tick(3); rd(4);
    wr(2, 32'h0040); ackVec(); rd(4);
    // R7: newest handler retired first, 5 still cannot preempt 4
    curReq = "R7";
    done(); rd(4); tick(2);
    done(); ackVec(); done(); rd(4);

    // R9: group saturation
    curReq = "R9";
    wr(5, 7); rd(5);
    wr(5, 32'hFFFF_FFFF); rd(5);

    // R6 with group 0: nothing preempts, R8 tail-chains afterwards
    curReq = "R6";
    wr(5, 0);
    wr(23, 15); wr(20, 0);
    wr(2, 32'h0080); ackVec();
    wr(2, 32'h0010); tick(3); rd(4);
    curReq = "R8";
    done(); ackVec(); done(); rd(4);

    // R10: done with nothing active
    curReq = "R10";
    rd(4); done(); rd(4); rd(2);

    // R3: enabling serviced waiting lines 9 and 12
    curReq = "R3";
    wr(5, 4); wr(25, 0); wr(28, 0);
    wr(0, 32'h1200); ackVec(); done(); ackVec(); done(); rd(2);

    // R4: random mix against the model
    curReq = "R4";
    for (int k = 0; k < 4000; k++) begin
      irqReq = N'($urandom);
      vecAck = mVv && ($urandom % 3 == 0);
      handlerDone = ($urandom % 6 == 0);
      regWe = ($urandom % 5 == 0);
      regAddr = RAW'($urandom % (16 + N));
      if (regWe && regAddr == RAW'(1)) regWdata = $urandom & 32'h0000_0003;
      else regWdata = $urandom;
      tick(1);
    end
    irqReq = '0; vecAck = 1'b0; handlerDone = 1'b0; regWe = 1'b0;
    tick(4);

    finished = 1;
    summary();
    $finish;
  end
endmodule